// File: doc/BRIEF.md
# Receive Descriptor Ring Sequencer

This block sits between the drain side of a receive FIFO and a ring of receive-buffer descriptors. Each descriptor holds a device-ownership flag and a buffer length. The block caches the current and the next descriptor. It places each arriving frame byte at the next offset of the current buffer, and returns each buffer to the host once the buffer is full or the frame has ended.

When a frame outgrows the current buffer and the cached next descriptor is device-owned, the full buffer is returned at once. Storage moves on to the next buffer, and in the following cycle the block makes one read of the descriptor after that, whatever its ownership. When the next descriptor is not device-owned, the rest of the frame is dropped. The current descriptor is then closed with an error status. At every frame close the cached next entries become the current ones. Ring indices step by one and wrap at a power-of-two ring length.

The sequencer has seven named states. LOAD_CUR reads the current descriptor. LOAD_NXT reads the next descriptor and clears the per-frame counters. RUN stores bytes. LOOK makes the single look-ahead read after a chaining step. DROP discards bytes after a buffer overrun. SKIP discards a frame that started on a descriptor the device does not own. CLOSE writes the final status.

The transitions are:
- LOAD_CUR goes to LOAD_NXT.
- LOAD_NXT goes to RUN.
- RUN goes to LOOK on a chaining write.
- RUN goes to CLOSE on the last byte, or when the last byte is the one that overruns.
- RUN goes to DROP when a byte that is not the last finds no room.
- RUN goes to SKIP or LOAD_CUR when the current descriptor is not owned.
- LOOK goes to RUN, or to CLOSE when the byte it accepts is the last.
- DROP goes to CLOSE on the last byte.
- SKIP goes to LOAD_CUR on the last byte.
- CLOSE goes to LOAD_NXT.

Top module: `rx_desc_seq`

## Requirements
- R1: After reset the block reads descriptor 0 in the first cycle and descriptor 1 in the second, with no byte accepted and no writes during those cycles.
- R2: Each stored byte appears on the buffer write port with the current descriptor index and with consecutive offsets that start at 0 for each buffer, in the same cycle the byte is accepted.
- R3: When a byte that is not the last fills the current buffer and the next descriptor is device-owned, a descriptor write goes out in that same cycle. It carries the current index, ownership 0, both error flags 0, end flag 0, and count equal to the frame bytes stored so far. The following bytes go to the next index, starting at offset 0.
- R4: In the cycle after a chaining write, the block reads the descriptor two places beyond the one just returned, whatever its ownership. It makes no descriptor read in the cycle after that.
- R5: During the look-ahead cycle, a byte is accepted only if it does not fill the newly current buffer: in_ready equals (new buffer length > 1).
- R6: In the cycle after the last byte of a frame is stored, a descriptor write goes out. It carries ownership 0, end flag 1, both error flags 0, and count equal to the total bytes of the frame.
- R7: When a byte finds the current buffer full and the next descriptor is not device-owned, the frame is closed with a descriptor write to the current index. That write carries ownership 0, buffer-error 1, end flag 0, and count equal to the bytes stored. It happens in the cycle after the end-of-frame byte is accepted. Overflow-error is 1 exactly when more than one byte of the frame was discarded.
- R8: After such an overrun, the remaining bytes of the frame are accepted and produce no buffer writes.
- R9: After any frame close, the next frame uses the cached next descriptor as current without reading it again. In the cycle after the close write, the block reads the descriptor two places beyond the closed one and holds in_ready low.
- R10: A frame that starts while the current descriptor is not device-owned is consumed with no buffer write and no descriptor write. While no byte is offered in that condition, the block reads the current and next descriptors again.
- R11: All descriptor indices advance by one modulo RING, a power of two from 1 to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A FIFO byte is offered |
| in_ready | output | 1 | The block takes the offered byte this cycle |
| in_data | input | DATA_W | Offered byte |
| in_last | input | 1 | Offered byte ends the frame |
| dr_en | output | 1 | Descriptor read strobe |
| dr_idx | output | IW | Descriptor read index |
| dr_own | input | 1 | Ownership flag of the read descriptor, same cycle |
| dr_len | input | LEN_W | Buffer length of the read descriptor, same cycle |
| dw_en | output | 1 | Descriptor status write strobe |
| dw_idx | output | IW | Descriptor write index |
| dw_own | output | 1 | Ownership value written |
| dw_buf_err | output | 1 | Buffer-error flag written |
| dw_ovf_err | output | 1 | Overflow-error flag written |
| dw_eop | output | 1 | End-of-frame flag written |
| dw_cnt | output | CNT_W | Frame byte count written |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_idx | output | IW | Descriptor index of the buffer written |
| buf_off | output | LEN_W | Byte offset inside that buffer |
| buf_data | output | DATA_W | Byte written |

## Verification
The assertions assume three things about the inputs. Descriptor read data arrives combinationally in the cycle of the read. Buffer lengths are nonzero. The host never changes the ownership or length of the two cached descriptors, and changes nothing while a frame is in flight.

The stimulus keeps to these rules. It changes descriptors only between frames, and only those at least two places ahead of the next start. It re-arms the stuck current descriptor only after a skipped frame, and then waits idle long enough for a fresh poll. Frame lengths and buffer lengths are bounded so that no frame's reads wrap back onto descriptors it has already returned.

// File: rtl/rx_desc_pkg.sv
package rx_desc_pkg;

    typedef enum logic [2:0] {
        ST_LOAD_CUR,
        ST_LOAD_NXT,
        ST_RUN,
        ST_LOOK,
        ST_DROP,
        ST_SKIP,
        ST_CLOSE
    } seq_state_e;

endpackage

// File: rtl/rx_ring_step.sv
// Ring index successor, modulo a power-of-two ring length.
module rx_ring_step #(
    parameter int RING = 8,
    localparam int IW = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic [IW-1:0] idx_i,
    output logic [IW-1:0] idx_o
);

    generate
        if (RING == 1) begin : g_single
            assign idx_o = '0;
        end else begin : g_pow2
            // Width equals log2(RING), so the carry out wraps the index.
            assign idx_o = idx_i + 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rx_desc_seq.sv
module rx_desc_seq
    import rx_desc_pkg::*;
#(
    parameter int RING   = 8,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8,
    localparam int IW = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              dr_en,
    output logic [IW-1:0]     dr_idx,
    input  logic              dr_own,
    input  logic [LEN_W-1:0]  dr_len,
    output logic              dw_en,
    output logic [IW-1:0]     dw_idx,
    output logic              dw_own,
    output logic              dw_buf_err,
    output logic              dw_ovf_err,
    output logic              dw_eop,
    output logic [CNT_W-1:0]  dw_cnt,
    output logic              buf_we,
    output logic [IW-1:0]     buf_idx,
    output logic [LEN_W-1:0]  buf_off,
    output logic [DATA_W-1:0] buf_data
);

    seq_state_e state_q, state_d;

    logic [IW-1:0]    cur_idx;
    logic [IW-1:0]    idx_inc;
    logic             cur_own, nxt_own;
    logic [LEN_W-1:0] cur_len, nxt_len;
    logic [LEN_W-1:0] fill_q;
    logic [CNT_W-1:0] total_q;
    logic             err_q, ovf_q;

    logic [LEN_W:0]   fill_inc;
    logic             has_room;
    logic             fills;

    rx_ring_step #(.RING(RING)) u_step (
        .idx_i (cur_idx),
        .idx_o (idx_inc)
    );

    assign fill_inc = {1'b0, fill_q} + 1'b1;
    assign has_room = fill_q < cur_len;
    assign fills    = fill_inc == {1'b0, cur_len};

    assign dw_idx   = cur_idx;
    assign buf_idx  = cur_idx;
    assign buf_off  = fill_q;
    assign buf_data = in_data;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD_CUR;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        in_ready   = 1'b0;
        dr_en      = 1'b0;
        dr_idx     = cur_idx;
        dw_en      = 1'b0;
        dw_own     = 1'b0;
        dw_buf_err = 1'b0;
        dw_ovf_err = 1'b0;
        dw_eop     = 1'b0;
        dw_cnt     = total_q;
        buf_we     = 1'b0;
        unique case (state_q)
            ST_LOAD_CUR: begin
                dr_en   = 1'b1;
                state_d = ST_LOAD_NXT;
            end
            ST_LOAD_NXT: begin
                dr_en   = 1'b1;
                dr_idx  = idx_inc;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                in_ready = 1'b1;
                if (!cur_own) begin
                    // Unowned start: drop the frame, or poll when idle.
                    if (in_valid) state_d = in_last ? ST_LOAD_CUR : ST_SKIP;
                    else          state_d = ST_LOAD_CUR;
                end else if (in_valid) begin
                    if (has_room) begin
                        buf_we = 1'b1;
                        if (in_last) begin
                            state_d = ST_CLOSE;
                        end else if (fills && nxt_own) begin
                            // Return the full buffer at once and chain.
                            dw_en   = 1'b1;
                            dw_cnt  = total_q + 1'b1;
                            state_d = ST_LOOK;
                        end
                    end else begin
                        state_d = in_last ? ST_CLOSE : ST_DROP;
                    end
                end
            end
            ST_LOOK: begin
                dr_en    = 1'b1;
                dr_idx   = idx_inc;
                in_ready = fill_inc < {1'b0, cur_len};
                buf_we   = in_valid && in_ready;
                state_d  = (buf_we && in_last) ? ST_CLOSE : ST_RUN;
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) state_d = ST_CLOSE;
            end
            ST_SKIP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) state_d = ST_LOAD_CUR;
            end
            ST_CLOSE: begin
                dw_en      = 1'b1;
                dw_eop     = !err_q;
                dw_buf_err = err_q;
                dw_ovf_err = ovf_q;
                state_d    = ST_LOAD_NXT;
            end
            default: state_d = ST_LOAD_CUR;
        endcase
    end

    // Descriptor cache and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
            cur_own <= 1'b0;
            cur_len <= '0;
            nxt_own <= 1'b0;
            nxt_len <= '0;
            fill_q  <= '0;
            total_q <= '0;
            err_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LOAD_CUR: begin
                    cur_own <= dr_own;
                    cur_len <= dr_len;
                end
                ST_LOAD_NXT: begin
                    nxt_own <= dr_own;
                    nxt_len <= dr_len;
                    fill_q  <= '0;
                    total_q <= '0;
                    err_q   <= 1'b0;
                    ovf_q   <= 1'b0;
                end
                ST_RUN: begin
                    if (buf_we) begin
                        fill_q  <= fill_inc[LEN_W-1:0];
                        total_q <= total_q + 1'b1;
                    end
                    if (dw_en) begin
                        cur_idx <= idx_inc;
                        cur_own <= nxt_own;
                        cur_len <= nxt_len;
                        fill_q  <= '0;
                    end
                    if (in_valid && cur_own && !has_room) err_q <= 1'b1;
                end
                ST_LOOK: begin
                    // Single look-ahead, stored whatever its ownership.
                    nxt_own <= dr_own;
                    nxt_len <= dr_len;
                    if (buf_we) begin
                        fill_q  <= fill_inc[LEN_W-1:0];
                        total_q <= total_q + 1'b1;
                    end
                end
                ST_DROP: begin
                    if (in_valid) ovf_q <= 1'b1;
                end
                ST_CLOSE: begin
                    cur_idx <= idx_inc;
                    cur_own <= nxt_own;
                    cur_len <= nxt_len;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rx_desc_seq_chk.sv
module rx_desc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_last,
    input logic dr_en,
    input logic dw_en,
    input logic dw_eop,
    input logic dw_buf_err,
    input logic buf_we
);

    // R2: a buffer write only for an accepted byte
    a_r2_store_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (in_valid && in_ready));

    // R4: a chaining write is followed by the look-ahead read
    a_r4_look_after_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_en && !dw_eop && !dw_buf_err) |=> dr_en);

    // R4: the look-ahead read is not repeated
    a_r4_look_once: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_en && !dw_eop && !dw_buf_err) |=> ##1 !dr_en);

    // R6: final status follows the last stored byte
    a_r6_eop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && in_last) |=> (dw_en && dw_eop));

    // R9: a close is followed by the read of the new next descriptor
    a_r9_close_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_en && (dw_eop || dw_buf_err)) |=> (dr_en && !in_ready));

endmodule

bind rx_desc_seq rx_desc_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .dr_en      (dr_en),
    .dw_en      (dw_en),
    .dw_eop     (dw_eop),
    .dw_buf_err (dw_buf_err),
    .buf_we     (buf_we)
);

// File: tb/rx_desc_seq_tb.sv
module rx_desc_seq_tb;

    localparam int RING   = 8;
    localparam int LEN_W  = 8;
    localparam int CNT_W  = 12;
    localparam int DATA_W = 8;
    localparam int IW     = 3;
    localparam int NFRM   = 300;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              in_valid, in_ready, in_last;
    logic [DATA_W-1:0] in_data;
    logic              dr_en, dr_own;
    logic [IW-1:0]     dr_idx;
    logic [LEN_W-1:0]  dr_len;
    logic              dw_en, dw_own, dw_buf_err, dw_ovf_err, dw_eop;
    logic [IW-1:0]     dw_idx;
    logic [CNT_W-1:0]  dw_cnt;
    logic              buf_we;
    logic [IW-1:0]     buf_idx;
    logic [LEN_W-1:0]  buf_off;
    logic [DATA_W-1:0] buf_data;

    logic             mem_own [RING];
    logic [LEN_W-1:0] mem_len [RING];

    assign dr_own = mem_own[dr_idx];
    assign dr_len = mem_len[dr_idx];

    rx_desc_seq #(.RING(RING), .LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .dr_en(dr_en), .dr_idx(dr_idx), .dr_own(dr_own), .dr_len(dr_len),
        .dw_en(dw_en), .dw_idx(dw_idx), .dw_own(dw_own), .dw_buf_err(dw_buf_err),
        .dw_ovf_err(dw_ovf_err), .dw_eop(dw_eop), .dw_cnt(dw_cnt),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_off(buf_off), .buf_data(buf_data)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nx(input int i, input int d);
        return (i + d) % RING;
    endfunction

    // Logs gathered by the monitor
    int g_nb, g_nd;
    int g_bidx [64];
    int g_boff [64];
    int g_bdat [64];
    int g_didx [16];
    int g_dflg [16];
    int g_dcnt [16];

    // Expected values from the model
    int e_nb, e_nd, e_next;
    bit e_skip, e_err, e_ovf, e_chain;
    int e_bidx [64];
    int e_boff [64];
    int e_didx [16];
    int e_dflg [16];
    int e_dcnt [16];

    // Timing monitor, sampling away from the active edge
    bit p_chain = 0, p_look = 0, p_close = 0, p_last = 0;
    int p_idx = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                if (g_nb < 64) begin
                    g_bidx[g_nb] = int'(buf_idx);
                    g_boff[g_nb] = int'(buf_off);
                    g_bdat[g_nb] = int'(buf_data);
                end
                g_nb++;
            end
            if (dw_en) begin
                if (g_nd < 16) begin
                    g_didx[g_nd] = int'(dw_idx);
                    g_dflg[g_nd] = int'({dw_own, dw_buf_err, dw_ovf_err, dw_eop});
                    g_dcnt[g_nd] = int'(dw_cnt);
                end
                g_nd++;
                mem_own[dw_idx] <= dw_own;
            end
            if (p_chain) begin
                check(dr_en && int'(dr_idx) == nx(p_idx, 2), "R4 look-ahead index",
                      int'(dr_idx), nx(p_idx, 2));
                check(in_ready == (mem_len[nx(p_idx, 1)] > 1), "R5 look-cycle ready",
                      int'(in_ready), int'(mem_len[nx(p_idx, 1)] > 1));
            end
            if (p_look)  check(!dr_en, "R4 single look-ahead", int'(dr_en), 0);
            if (p_close) check(dr_en && !in_ready && int'(dr_idx) == nx(p_idx, 2),
                               "R9 reload after close", int'(dr_idx), nx(p_idx, 2));
            if (p_last)  check(dw_en && dw_eop, "R6 close timing", int'(dw_en && dw_eop), 1);
            p_look  = p_chain;
            p_chain = dw_en && !dw_eop && !dw_buf_err;
            p_close = dw_en && (dw_eop || dw_buf_err);
            p_idx   = int'(dw_idx);
            p_last  = buf_we && in_last;
        end
    end

    // Model of one frame from start index c with length n
    task automatic model(input int c, input int n);
        int b, stored, rem, cap;
        e_nb = 0; e_nd = 0; e_skip = 0; e_err = 0; e_ovf = 0; e_chain = 0;
        e_next = c;
        if (!mem_own[c]) begin
            e_skip = 1;
            return;
        end
        b = c;
        stored = 0;
        forever begin
            cap = int'(mem_len[b]);
            rem = n - stored;
            if (rem <= cap) begin
                for (int k = 0; k < rem; k++) begin
                    e_bidx[e_nb] = b; e_boff[e_nb] = k; e_nb++;
                end
                e_didx[e_nd] = b; e_dflg[e_nd] = 4'b0001; e_dcnt[e_nd] = n; e_nd++;
                e_next = nx(b, 1);
                return;
            end
            for (int k = 0; k < cap; k++) begin
                e_bidx[e_nb] = b; e_boff[e_nb] = k; e_nb++;
            end
            stored += cap;
            if (mem_own[nx(b, 1)]) begin
                e_didx[e_nd] = b; e_dflg[e_nd] = 4'b0000; e_dcnt[e_nd] = stored; e_nd++;
                e_chain = 1;
                b = nx(b, 1);
            end else begin
                e_err = 1;
                e_ovf = (rem - cap) > 1;
                e_didx[e_nd] = b;
                e_dflg[e_nd] = e_ovf ? 4'b0110 : 4'b0100;
                e_dcnt[e_nd] = stored;
                e_nd++;
                e_next = nx(b, 1);
                return;
            end
        end
    endtask

    task automatic send_frame(input int n, input int d0);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_data  = DATA_W'(d0 + k);
            in_last  = (k == n - 1);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
            if ($urandom % 4 == 0) begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int c, n, d0, n_chain, n_err, n_ovf, n_skip, n_wrap, n_exact;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        g_nb = 0; g_nd = 0;
        for (int i = 0; i < RING; i++) begin
            mem_own[i] = 1'b1;
            mem_len[i] = LEN_W'(6 + $urandom % 11);
        end
        mem_len[0] = 8'd6;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: first two cycles read descriptors 0 and 1
        @(negedge clk);
        check(dr_en && dr_idx == 0, "R1 first read", int'(dr_idx), 0);
        check(!in_ready && !dw_en && !buf_we, "R1 quiet outputs", int'(in_ready), 0);
        @(negedge clk);
        check(dr_en && dr_idx == 1, "R1 second read", int'(dr_idx), 1);
        check(!in_ready && !dw_en && !buf_we, "R1 quiet outputs", int'(in_ready), 0);
        idle(2);

        c = 0; n_chain = 0; n_err = 0; n_ovf = 0; n_skip = 0; n_wrap = 0; n_exact = 0;
        for (int f = 0; f < NFRM; f++) begin
            n = 1 + $urandom % 30;
            if (f % 7 == 0) n = int'(mem_len[c]);
            if (f % 11 == 0) n = int'(mem_len[c]) + 1;
            d0 = $urandom % 256;
            model(c, n);
            if (!e_skip && !e_chain && !e_err && n == int'(mem_len[c])) n_exact++;
            g_nb = 0; g_nd = 0;
            send_frame(n, d0);
            idle(6);
            check(g_nb == e_nb, e_skip ? "R10 no stores" : (e_err ? "R8 stored count" : "R2 stored count"), g_nb, e_nb);
            check(g_nd == e_nd, e_skip ? "R10 no status" : "R6 status count", g_nd, e_nd);
            if (g_nb == e_nb) begin
                for (int k = 0; k < e_nb; k++) begin
                    check(g_bidx[k] == e_bidx[k], "R11 buffer index", g_bidx[k], e_bidx[k]);
                    check(g_boff[k] == e_boff[k], "R2 buffer offset", g_boff[k], e_boff[k]);
                    check(g_bdat[k] == ((d0 + k) % 256), "R2 buffer data", g_bdat[k], (d0 + k) % 256);
                end
            end
            if (g_nd == e_nd) begin
                for (int k = 0; k < e_nd; k++) begin
                    check(g_didx[k] == e_didx[k], "R9 status index", g_didx[k], e_didx[k]);
                    if (e_dflg[k] == 0)
                        check(g_dflg[k] == 0 && g_dcnt[k] == e_dcnt[k], "R3 chain write",
                              g_dflg[k] * 4096 + g_dcnt[k], e_dcnt[k]);
                    else if (e_dflg[k] == 1)
                        check(g_dflg[k] == 1 && g_dcnt[k] == e_dcnt[k], "R6 end status",
                              g_dflg[k] * 4096 + g_dcnt[k], 4096 + e_dcnt[k]);
                    else
                        check(g_dflg[k] == e_dflg[k] && g_dcnt[k] == e_dcnt[k], "R7 error status",
                              g_dflg[k] * 4096 + g_dcnt[k], e_dflg[k] * 4096 + e_dcnt[k]);
                end
            end
            if (e_chain) n_chain++;
            if (e_err)   n_err++;
            if (e_ovf)   n_ovf++;
            if (e_skip) begin
                n_skip++;
                mem_len[c] = LEN_W'(6 + $urandom % 11);
                mem_own[c] = 1'b1;
                mem_own[nx(c, 1)] = ($urandom % 4) != 0;
                idle(8);
            end else begin
                if (e_next < c) n_wrap++;
                c = e_next;
                for (int d = 2; d < RING; d++) begin
                    mem_own[nx(c, d)] = ($urandom % 4) != 0;
                    mem_len[nx(c, d)] = LEN_W'(6 + $urandom % 11);
                end
                idle(2);
            end
        end
        check(n_chain > 0, "R3 chaining exercised", n_chain, 1);
        check(n_err > 0,   "R7 overrun exercised", n_err, 1);
        check(n_ovf > 0,   "R7 overflow flag exercised", n_ovf, 1);
        check(n_skip > 0,  "R10 unowned start exercised", n_skip, 1);
        check(n_wrap > 0,  "R11 ring wrap exercised", n_wrap, 1);
        check(n_exact > 0, "R6 exact fit exercised", n_exact, 1);
        finish_run();
    end

endmodule